// File: doc/BRIEF.md
# Reset Hold Duration Counter

This block measures how long an active-low external reset input stays asserted, so that software can tell a short press from a long one. A long press can then start a factory reset. It runs on the reference clock, which is 25 MHz in the intended system (40 ns per count). The external input is brought into that clock domain through a synchronizer. While the synchronized input is low, a saturating counter advances once per clock. The count is held after the input is released. Software reads the count through a simple word-addressed register port and clears it by writing a one to the top bit of the counter word.

The same register port holds a two-step software reset control. Software must first set an enable bit in the mask word. A later write of the trigger bit then raises a registered reset-out request. That request stays high until the block's own reset. A trigger written while the enable bit is clear is discarded.

The register map uses word addresses: 0 is the counter, 1 is the mask and 2 is the trigger. Reads are combinational from `bus_addr`. Writes take effect at the rising clock edge where `bus_wr` is high.

Top module: `rst_hold_meter`

## Requirements
- R1: While the synchronized reset input is low and the count is below its maximum, the count rises by exactly one on each clock edge.
- R2: The input passes through a two-flop synchronizer. Suppose it goes low before edge k. The first increment then happens at edge k+2, and the count still reads 0 after edges k and k+1. An input held low across N edges adds exactly N to the count.
- R3: The count is CNT_W bits wide (default 29). On reaching all ones (2^CNT_W-1), it stays there until it is cleared.
- R4: A write to address 0 with bit 31 set clears the count to 0 at that edge. The clear wins over a simultaneous increment.
- R5: A write to address 0 with bit 31 clear leaves the count unchanged.
- R6: A read of address 0 returns the count in bits [CNT_W-1:0], and zeros in all bits above it.
- R7: The count holds its value while the input is high. A new low period continues from the held value unless the count was cleared first.
- R8: Address 1 holds the reset-out enable in bit 2. Writes set or clear that bit. Reads return it in bit 2 and zeros in all other bits.
- R9: A write to address 2 with bit 0 set raises `rst_req` at that edge only if bit 2 of address 1 is already set. After such a write, a read of address 2 returns 1 in bit 0. Without the enable, the write has no effect: `rst_req` stays 0 and address 2 reads 0.
- R10: Once high, `rst_req` stays high until `rst_n` is asserted, whatever is written afterwards.
- R11: After `rst_n` is low at a clock edge, the count, the enable bit, the trigger bit and `rst_req` are all 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| ext_rst_n | input | 1 | Asynchronous active-low reset input being measured |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| rst_req | output | 1 | Sticky reset-out request |

## Verification
The bench counts the exact edges of synchronizer latency on both the falling and the rising side of the input. A design with one stage too few or too many would read a count that is off by one. It drives the count into saturation and then holds the input low again. A design that wraps would read a small value instead of all ones. It clears the count while the input is still low, and it writes a counter word without the clear bit. These catch designs where an increment beats the clear, or where any write to the word clears it. It tries the trigger before the enable, and again after it. A design that ignores the enable would raise the reset request too early, and one that lets later writes drop the request would fail the sticky check.

// File: rtl/rhm_pkg.sv
// Shared register map constants and address decode for the reset hold meter.
package rhm_pkg;

    localparam int unsigned REG_COUNT = 0;
    localparam int unsigned REG_ENABLE = 1;
    localparam int unsigned REG_TRIGGER = 2;

    localparam int unsigned ENABLE_BIT = 2;
    localparam int unsigned TRIGGER_BIT = 0;

    typedef enum logic [1:0] {
        SEL_COUNT,
        SEL_ENABLE,
        SEL_TRIGGER,
        SEL_NONE
    } reg_sel_e;

    // Map a word address onto the register it selects.
    function automatic reg_sel_e decode_addr(input int unsigned addr);
        case (addr)
            REG_COUNT:   return SEL_COUNT;
            REG_ENABLE:  return SEL_ENABLE;
            REG_TRIGGER: return SEL_TRIGGER;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rhm_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2. The flops reset to RESET_VAL so that an idle
// input does not look active while the block is in reset.
module rhm_sync #(
    parameter int STAGES = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rhm_sat_counter.sv
// Saturating up-counter with a synchronous clear.
// It counts while 'run' is high and stops at all ones.
// A clear has priority over counting.
module rhm_sat_counter #(
    parameter int W = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] count_q;
    logic         at_max;

    assign at_max = (count_q == CNT_MAX);

    // Clear, advance or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (run && !at_max) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/rhm_regs.sv
// Register port for the reset hold meter. It holds the reset-out enable,
// the soft trigger and the sticky request, produces the counter clear
// strobe, and muxes read data. Assumes CNT_W < DATA_W.
module rhm_regs
    import rhm_pkg::*;
#(
    parameter int CNT_W = 29,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              count_clr,
    output logic              rst_req
);

    localparam int CLR_BIT = DATA_W - 1;
    localparam int PAD_W = DATA_W - CNT_W;

    reg_sel_e sel;
    logic     enable_q;
    logic     trigger_q;
    logic     req_q;
    logic     trig_fire;

    assign sel = decode_addr(int'(bus_addr));
    assign count_clr = bus_wr && (sel == SEL_COUNT) && bus_wdata[CLR_BIT];
    assign trig_fire = bus_wr && (sel == SEL_TRIGGER) && bus_wdata[TRIGGER_BIT] && enable_q;

    // Load the reset-out enable bit from writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
        end else if (bus_wr && (sel == SEL_ENABLE)) begin
            enable_q <= bus_wdata[ENABLE_BIT];
        end
    end

    // Record an accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trigger_q <= 1'b0;
        end else if (trig_fire) begin
            trigger_q <= 1'b1;
        end
    end

    // Keep the reset-out request high once it has been raised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (trig_fire) begin
            req_q <= 1'b1;
        end
    end

    // Select read data for the addressed word.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_COUNT:   bus_rdata = {{PAD_W{1'b0}}, count};
            SEL_ENABLE:  bus_rdata[ENABLE_BIT] = enable_q;
            SEL_TRIGGER: bus_rdata[TRIGGER_BIT] = trigger_q;
            default:     bus_rdata = '0;
        endcase
    end

    assign rst_req = req_q;

endmodule

// File: rtl/rst_hold_meter.sv
// Reset hold duration meter. It synchronizes the external active-low
// reset, counts the clocks it stays low with a saturating counter, and
// exposes the count and the soft reset control on a register port.
// Assumes clk is the free-running reference clock.
module rst_hold_meter #(
    parameter int CNT_W = 29,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    logic             ext_sync;
    logic             ext_low_sync;
    logic             count_clr;
    logic [CNT_W-1:0] count;

    rhm_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(ext_rst_n),
        .q_sync (ext_sync)
    );

    assign ext_low_sync = ~ext_sync;

    rhm_sat_counter #(
        .W(CNT_W)
    ) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ext_low_sync),
        .clr  (count_clr),
        .count(count)
    );

    rhm_regs #(
        .CNT_W (CNT_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .count    (count),
        .bus_rdata(bus_rdata),
        .count_clr(count_clr),
        .rst_req  (rst_req)
    );

endmodule

// File: rtl/rhm_checker.sv
// Property checker for rst_hold_meter. It keeps its own copy of the
// enable bit, taken from bus writes.
module rhm_checker #(
    parameter int CNT_W = 29,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_rst_n,
    input logic              sync_low,
    input logic [CNT_W-1:0]  count,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rst_req
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic clr_wr;
    logic trig_wr;
    logic shadow_en;

    assign clr_wr = bus_wr && (bus_addr == 0) && bus_wdata[DATA_W-1];
    assign trig_wr = bus_wr && (bus_addr == 2) && bus_wdata[0];

    // Track the enable bit from the bus side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_en <= 1'b0;
        end else if (bus_wr && (bus_addr == 1)) begin
            shadow_en <= bus_wdata[2];
        end
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_low && !clr_wr && count != CMAX) |=> count == $past(count) + 1'b1);

    assert_sync_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_low |-> $past(ext_rst_n, 2) == 1'b0);

    assert_sat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CMAX && !clr_wr) |=> count == CMAX);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> count == '0);

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 0) |-> bus_rdata[DATA_W-1:CNT_W] == '0);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_low && !clr_wr) |=> $stable(count));

    assert_req_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(trig_wr && shadow_en));

    assert_req_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

endmodule

bind rst_hold_meter rhm_checker #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_rst_n(ext_rst_n),
    .sync_low (ext_low_sync),
    .count    (count),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rst_req  (rst_req)
);

// File: tb/test_rst_hold_meter.sv
module test_rst_hold_meter;

    localparam int CW = 8;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NV = 7;
    // Vector table: clear first?, low cycles, expected count afterwards.
    localparam int V_CLR[NV]  = '{1, 0, 1, 1, 0, 0, 1};
    localparam int V_HOLD[NV] = '{5, 3, 0, 250, 10, 2, 1};
    localparam int V_EXP[NV]  = '{5, 8, 0, 250, 255, 255, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_rst_n = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          rst_req;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] rd;

    always #4 clk = ~clk;

    rst_hold_meter #(.CNT_W(CW), .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) i_rst_hold_meter (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        bus_addr = AW'(a);
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rdreg(input int a, output logic [DW-1:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic hold_low(input int n);
        if (n > 0) begin
            ext_rst_n = 1'b0;
            tick(n);
            ext_rst_n = 1'b1;
        end
        tick(3);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        // R11 reset state
        rdreg(0, rd); check("R11 count", rd, 0);
        rdreg(1, rd); check("R11 enable", rd, 0);
        rdreg(2, rd); check("R11 trigger", rd, 0);
        rdreg(5, rd); check("R11 unmapped", rd, 0);
        check("R11 rst_req", {31'd0, rst_req}, 0);
        rst_n = 1'b1;
        tick(1);

        // R1 R3 R6 R7 vector table
        for (int i = 0; i < NV; i++) begin
            if (V_CLR[i] != 0) wr(0, 32'h8000_0000);
            hold_low(V_HOLD[i]);
            rdreg(0, rd);
            check("R1/R3/R6/R7 vector", rd, DW'(V_EXP[i]));
        end

        // R2 synchronizer latency
        wr(0, 32'h8000_0000);
        ext_rst_n = 1'b0;
        tick(2);
        rdreg(0, rd); check("R2 no count yet", rd, 0);
        tick(1);
        rdreg(0, rd); check("R2 first increment", rd, 1);
        ext_rst_n = 1'b1;
        tick(3);
        rdreg(0, rd); check("R2 release lag", rd, 3);

        // R4 clear while counting
        ext_rst_n = 1'b0;
        tick(5);
        wr(0, 32'h8000_0000);
        ext_rst_n = 1'b1;
        rdreg(0, rd); check("R4 clear wins", rd, 0);
        tick(3);
        rdreg(0, rd); check("R4 after clear", rd, 2);

        // R5 write without clear bit
        wr(0, 32'h7FFF_FFFF);
        rdreg(0, rd); check("R5 no effect", rd, 2);

        // R8 R9 enable and trigger
        wr(1, 32'hFFFF_FFFB);
        rdreg(1, rd); check("R8 enable clear", rd, 0);
        wr(2, 32'h0000_0001);
        check("R9 no req without enable", {31'd0, rst_req}, 0);
        rdreg(2, rd); check("R9 trigger dropped", rd, 0);
        wr(1, 32'hFFFF_FFFF);
        rdreg(1, rd); check("R8 enable set", rd, 32'h4);
        check("R9 enable alone", {31'd0, rst_req}, 0);
        wr(2, 32'h0000_0001);
        check("R9 req raised", {31'd0, rst_req}, 1);
        rdreg(2, rd); check("R9 trigger read", rd, 1);

        // R10 sticky request
        wr(2, 32'h0);
        wr(1, 32'h0);
        tick(2);
        check("R10 sticky", {31'd0, rst_req}, 1);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R10 cleared by reset", {31'd0, rst_req}, 0);
        rdreg(0, rd); check("R11 count after reset", rd, 0);
        rdreg(1, rd); check("R11 enable after reset", rd, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule